// File: doc/BRIEF.md
# Vectored Interrupt Priority Unit

This unit sits next to a processor's sequencer. It watches five interrupt request lines and, when the core signals an instruction boundary, picks the highest-ranked request that may be taken. The five lines are a non-maskable trap, three maskable restart lines (ranked 7.5, 6.5 and 5.5) and one general request. A global enable flag is set by an enable strobe and cleared by a disable strobe. A three-bit mask register gates the restart lines one by one. The 7.5 line is edge-triggered and keeps its request in a pending latch. The other lines are sampled as levels.

The trap and restart lines have fixed entry addresses. The general request has none. For it, the unit runs an acknowledge phase, holding `inta_o` high. During that phase a small built-in responder places a restart-4 opcode on the internal data bus, unless an external device takes the bus instead. The opcode present on the last acknowledge cycle is captured, and bits 5:3 of it select the entry address.

The chosen entry address is offered on a valid/ready output. `irq_valid_o` stays high, and the vector, source code and opcode stay stable, until the core accepts them with `irq_ready_i`. While an offer is outstanding, no new decision is made. Stacking the return address and running the service routine are left to the core.

Top module: `vip_unit`

## Requirements
- R1: Fixed entry addresses are 0x0024 for the trap, 0x003C for restart 7.5, 0x0034 for restart 6.5 and 0x002C for restart 5.5. The source code is 0 for trap, 1 for 7.5, 2 for 6.5, 3 for 5.5 and 4 for the general request.
- R2: After reset, the global enable is 0, the mask is 3'b111, the 7.5 pending latch is clear, and `irq_valid_o` and `inta_o` are low.
- R3: An enable strobe sets the global enable from the next cycle on. A disable strobe clears it. When both strobes come in the same cycle, the disable wins.
- R4: A restart line is taken only when the global enable is 1 and its mask bit is 0. Mask bit 0 gates 5.5, bit 1 gates 6.5 and bit 2 gates 7.5. A mask write loads all three bits on the next edge.
- R5: The trap is taken regardless of the global enable and the mask.
- R6: When several requests may be taken, the fixed ranking is trap, then 7.5, then 6.5, then 5.5, then the general request.
- R7: The general request is taken only while the global enable is 1. Once it is taken, `inta_o` is high for exactly INTA_CYCLES cycles, starting in the cycle after the boundary, and the bus is sampled in the last of those cycles.
- R8: Taking any interrupt clears the global enable. This clear overrides an enable strobe in the same cycle.
- R9: A rising edge on the 7.5 line sets a pending latch, shown on `pend75_o`. The latch holds even while masked, until the request is taken or cleared by `clr75_i`.
- R10: For the general request, the vector is the captured opcode's bits 5:3 times 8, and `irq_opcode_o` carries the opcode. The built-in responder drives 0xE7 (vector 0x0020). While `ext_drive_i` is high, the bus carries `ext_data_i` instead.
- R11: While `irq_valid_o` is high and `irq_ready_i` is low, the vector, source and opcode hold steady. Decisions are made only on a boundary cycle while no offer or acknowledge phase is in progress.
- R12: A fixed-vector request taken on a boundary cycle is offered in the next cycle. A general request is offered INTA_CYCLES+1 cycles after the boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_i | input | 1 | Non-maskable trap request (level) |
| rst75_i | input | 1 | Restart 7.5 request (rising edge) |
| rst65_i | input | 1 | Restart 6.5 request (level) |
| rst55_i | input | 1 | Restart 5.5 request (level) |
| intr_i | input | 1 | General request (level) |
| ei_i | input | 1 | Enable strobe for the global enable |
| di_i | input | 1 | Disable strobe for the global enable |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 3 | New mask value |
| clr75_i | input | 1 | Clears the 7.5 pending latch |
| boundary_i | input | 1 | Instruction boundary: decision cycle |
| ext_drive_i | input | 1 | An external device drives the bus |
| ext_data_i | input | 8 | Data driven by the external device |
| irq_ready_i | input | 1 | Core accepts the offered vector |
| inta_o | output | 1 | Acknowledge phase for the general request |
| irq_valid_o | output | 1 | Vector offer valid |
| irq_vector_o | output | 16 | Entry address |
| irq_src_o | output | 3 | Source code of the offer |
| irq_opcode_o | output | 8 | Captured opcode (0 for fixed sources) |
| ie_o | output | 1 | Global enable state |
| mask_o | output | 3 | Mask register state |
| pend75_o | output | 1 | 7.5 pending latch state |

## Verification
Several properties are checked on every cycle:
- the offer holds steady under back-pressure;
- each fixed source carries its own address;
- the acknowledge phase never overlaps an offer;
- the global enable is low whenever an acceptance first shows;
- the 7.5 latch drops only through service or an explicit clear.

The ranking among simultaneous requests, the exact length of the acknowledge phase, the bus capture with and without an external driver, and the latency from boundary to offer show only in the bench's scenarios. There they are compared against a behavioural model on every clock.

// File: rtl/vip_pkg.sv
package vip_pkg;
  localparam int N_SRC = 5;
  localparam int SRC_W = $clog2(N_SRC);
  localparam int VEC_W = 16;
  localparam int OP_W  = 8;
  localparam int MSK_W = 3;

  typedef enum logic [SRC_W-1:0] {
    SRC_TRAP = 3'd0,
    SRC_R75  = 3'd1,
    SRC_R65  = 3'd2,
    SRC_R55  = 3'd3,
    SRC_INTR = 3'd4
  } src_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_INTA  = 2'd1,
    ST_OFFER = 2'd2
  } st_e;

  // Half-step restart number k gives address (2k+9)*4: 4.5 -> 0x24 ... 7.5 -> 0x3C
  function automatic logic [VEC_W-1:0] fixed_vec(input src_e s);
    int k;
    case (s)
      SRC_TRAP: k = 0;
      SRC_R55:  k = 1;
      SRC_R65:  k = 2;
      SRC_R75:  k = 3;
      default:  k = 0;
    endcase
    return VEC_W'((2 * k + 9) * 4);
  endfunction

  function automatic logic [VEC_W-1:0] op_vec(input logic [OP_W-1:0] op);
    return {{(VEC_W-6){1'b0}}, op[5:3], 3'b000};
  endfunction
endpackage

// File: rtl/vip_edge_latch.sv
module vip_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q;
  logic pend_q;
  logic rise;

  assign rise = lvl_i & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      pend_q <= rise | (pend_q & ~clr_i);
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/vip_select.sv
module vip_select #(
  parameter int N = 5,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);
  // Lowest index ranks highest.
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vip_responder.sv
module vip_responder #(
  parameter int OP_W = 8,
  parameter logic [OP_W-1:0] OPCODE = 8'hE7
) (
  input  logic            inta_i,
  input  logic            ext_drive_i,
  input  logic [OP_W-1:0] ext_data_i,
  output logic [OP_W-1:0] bus_o
);
  logic [OP_W-1:0] own;

  assign own   = inta_i ? OPCODE : '0;
  assign bus_o = ext_drive_i ? ext_data_i : own;
endmodule

// File: rtl/vip_unit.sv
module vip_unit
  import vip_pkg::*;
#(
  parameter int INTA_CYCLES = 2,
  parameter logic [OP_W-1:0] RESP_OPCODE = 8'hE7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_i,
  input  logic             rst75_i,
  input  logic             rst65_i,
  input  logic             rst55_i,
  input  logic             intr_i,
  input  logic             ei_i,
  input  logic             di_i,
  input  logic             mask_we_i,
  input  logic [MSK_W-1:0] mask_wdata_i,
  input  logic             clr75_i,
  input  logic             boundary_i,
  input  logic             ext_drive_i,
  input  logic [OP_W-1:0]  ext_data_i,
  input  logic             irq_ready_i,
  output logic             inta_o,
  output logic             irq_valid_o,
  output logic [VEC_W-1:0] irq_vector_o,
  output logic [SRC_W-1:0] irq_src_o,
  output logic [OP_W-1:0]  irq_opcode_o,
  output logic             ie_o,
  output logic [MSK_W-1:0] mask_o,
  output logic             pend75_o
);
  localparam int CNT_W = $clog2(INTA_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INTA_CYCLES - 1);

  st_e              st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ie_q;
  logic [MSK_W-1:0] mask_q;
  logic [VEC_W-1:0] vec_q;
  logic [OP_W-1:0]  op_q;
  src_e             src_q;
  logic             pend75;
  logic [N_SRC-1:0] req;
  logic             hit;
  logic [SRC_W-1:0] win;
  logic             take;
  logic             take75;
  logic             inta;
  logic [OP_W-1:0]  bus;

  vip_edge_latch u_latch75 (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (rst75_i),
    .clr_i (clr75_i | take75),
    .pend_o(pend75)
  );

  assign req[SRC_TRAP] = trap_i;
  assign req[SRC_R75]  = ie_q & ~mask_q[2] & pend75;
  assign req[SRC_R65]  = ie_q & ~mask_q[1] & rst65_i;
  assign req[SRC_R55]  = ie_q & ~mask_q[0] & rst55_i;
  assign req[SRC_INTR] = ie_q & intr_i;

  vip_select #(.N(N_SRC)) u_sel (
    .req_i(req),
    .hit_o(hit),
    .idx_o(win)
  );

  assign take   = (st_q == ST_IDLE) & boundary_i & hit;
  assign take75 = take & (win == SRC_R75);
  assign inta   = (st_q == ST_INTA);

  vip_responder #(.OP_W(OP_W), .OPCODE(RESP_OPCODE)) u_resp (
    .inta_i     (inta),
    .ext_drive_i(ext_drive_i),
    .ext_data_i (ext_data_i),
    .bus_o      (bus)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      mask_q <= '1;
    end else begin
      if (take)      ie_q <= 1'b0;
      else if (di_i) ie_q <= 1'b0;
      else if (ei_i) ie_q <= 1'b1;
      if (mask_we_i) mask_q <= mask_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      vec_q <= '0;
      op_q  <= '0;
      src_q <= SRC_TRAP;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (take) begin
            src_q <= src_e'(win);
            if (src_e'(win) == SRC_INTR) begin
              st_q  <= ST_INTA;
              cnt_q <= '0;
            end else begin
              st_q  <= ST_OFFER;
              vec_q <= fixed_vec(src_e'(win));
              op_q  <= '0;
            end
          end
        end
        ST_INTA: begin
          if (cnt_q == CNT_LAST) begin
            st_q  <= ST_OFFER;
            vec_q <= op_vec(bus);
            op_q  <= bus;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_OFFER: begin
          if (irq_ready_i) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign inta_o       = inta;
  assign irq_valid_o  = (st_q == ST_OFFER);
  assign irq_vector_o = vec_q;
  assign irq_src_o    = src_q;
  assign irq_opcode_o = op_q;
  assign ie_o         = ie_q;
  assign mask_o       = mask_q;
  assign pend75_o     = pend75;
endmodule

// File: rtl/vip_unit_checker.sv
module vip_unit_checker
  import vip_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             clr75_i,
  input logic             irq_ready_i,
  input logic             inta_o,
  input logic             irq_valid_o,
  input logic [VEC_W-1:0] irq_vector_o,
  input logic [SRC_W-1:0] irq_src_o,
  input logic [OP_W-1:0]  irq_opcode_o,
  input logic             ie_o,
  input logic             pend75_o
);
  a_r11_offer_stable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o && !irq_ready_i |=> irq_valid_o && $stable(irq_vector_o)
      && $stable(irq_src_o) && $stable(irq_opcode_o));

  a_r1_trap_vec: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o && irq_src_o == 3'd0 |-> irq_vector_o == 16'h0024);

  a_r1_r75_vec: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o && irq_src_o == 3'd1 |-> irq_vector_o == 16'h003C);

  a_r1_r65_vec: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o && irq_src_o == 3'd2 |-> irq_vector_o == 16'h0034);

  a_r1_r55_vec: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o && irq_src_o == 3'd3 |-> irq_vector_o == 16'h002C);

  a_r7_inta_excl: assert property (@(posedge clk) disable iff (!rst_n)
    inta_o |-> !irq_valid_o);

  a_r8_ie_off_inta: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inta_o) |-> !ie_o);

  a_r8_ie_off_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid_o) && irq_src_o != 3'd4 |-> !ie_o);

  a_r9_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pend75_o && !clr75_i |=> pend75_o || (irq_valid_o && irq_src_o == 3'd1));
endmodule

bind vip_unit vip_unit_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clr75_i     (clr75_i),
  .irq_ready_i (irq_ready_i),
  .inta_o      (inta_o),
  .irq_valid_o (irq_valid_o),
  .irq_vector_o(irq_vector_o),
  .irq_src_o   (irq_src_o),
  .irq_opcode_o(irq_opcode_o),
  .ie_o        (ie_o),
  .pend75_o    (pend75_o)
);

// File: tb/vip_unit_bench.sv
module vip_unit_bench;
  localparam int NINTA = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap = 0, r75 = 0, r65 = 0, r55 = 0, intr = 0;
  logic ei = 0, di = 0, mwe = 0, clr75 = 0, bnd = 0, xdrv = 0, rdy = 0;
  logic [2:0] mwd = 3'b000;
  logic [7:0] xdat = 8'h00;
  logic inta, valid, ie, pend;
  logic [15:0] vec;
  logic [2:0] src, msk;
  logic [7:0] opc;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vip_unit #(.INTA_CYCLES(NINTA)) u_vip_unit (
    .clk(clk), .rst_n(rst_n), .trap_i(trap), .rst75_i(r75), .rst65_i(r65),
    .rst55_i(r55), .intr_i(intr), .ei_i(ei), .di_i(di), .mask_we_i(mwe),
    .mask_wdata_i(mwd), .clr75_i(clr75), .boundary_i(bnd),
    .ext_drive_i(xdrv), .ext_data_i(xdat), .irq_ready_i(rdy),
    .inta_o(inta), .irq_valid_o(valid), .irq_vector_o(vec), .irq_src_o(src),
    .irq_opcode_o(opc), .ie_o(ie), .mask_o(msk), .pend75_o(pend)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Behavioural reference model, advanced on every rising edge.
  int m_state = 0;   // 0 idle, 1 acknowledge, 2 offer
  int m_cnt = 0;
  bit m_ie = 0, m_pend = 0, m_prev = 0;
  bit [2:0] m_mask = 3'b111;
  int m_src = 0;
  int m_vec = 0;
  int m_op = 0;

  always @(posedge clk) begin
    bit rise, tk;
    int sel;
    logic [7:0] b;
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_ie = 0; m_pend = 0; m_prev = 0;
      m_mask = 3'b111; m_src = 0; m_vec = 0; m_op = 0;
    end else begin
      rise = r75 && !m_prev;
      m_prev = r75;
      sel = -1;
      if (trap) sel = 0;
      else if (m_ie && !m_mask[2] && m_pend) sel = 1;
      else if (m_ie && !m_mask[1] && r65) sel = 2;
      else if (m_ie && !m_mask[0] && r55) sel = 3;
      else if (m_ie && intr) sel = 4;
      tk = (m_state == 0) && bnd && (sel >= 0);
      b = xdrv ? xdat : ((m_state == 1) ? 8'hE7 : 8'h00);
      m_pend = rise || (m_pend && !(clr75 || (tk && sel == 1)));
      if (mwe) m_mask = mwd;
      if (tk) m_ie = 0; else if (di) m_ie = 0; else if (ei) m_ie = 1;
      case (m_state)
        0: if (tk) begin
             m_src = sel;
             if (sel == 4) begin m_state = 1; m_cnt = 0; end
             else begin
               m_state = 2; m_op = 0;
               m_vec = (sel == 0) ? 'h24 : (sel == 1) ? 'h3C : (sel == 2) ? 'h34 : 'h2C;
             end
           end
        1: if (m_cnt == NINTA - 1) begin
             m_state = 2; m_op = b; m_vec = ((b >> 3) & 7) * 8;
           end else m_cnt++;
        default: if (rdy) m_state = 0;
      endcase
    end
    #2;
    if (rst_n) begin
      checks++;
      if (valid !== (m_state == 2)) begin errors++; $display("FAIL R11 valid: actual %b expected %b", valid, m_state == 2); end
      if (inta !== (m_state == 1)) begin errors++; $display("FAIL R7 inta: actual %b expected %b", inta, m_state == 1); end
      if (ie !== m_ie) begin errors++; $display("FAIL R3 ie: actual %b expected %b", ie, m_ie); end
      if (msk !== m_mask) begin errors++; $display("FAIL R4 mask: actual %b expected %b", msk, m_mask); end
      if (pend !== m_pend) begin errors++; $display("FAIL R9 pend: actual %b expected %b", pend, m_pend); end
      if (m_state == 2) begin
        if (vec !== 16'(m_vec)) begin errors++; $display("FAIL R1 vector: actual %h expected %h", vec, 16'(m_vec)); end
        if (src !== 3'(m_src)) begin errors++; $display("FAIL R6 source: actual %0d expected %0d", src, m_src); end
        if (opc !== 8'(m_op)) begin errors++; $display("FAIL R10 opcode: actual %h expected %h", opc, 8'(m_op)); end
      end
    end
  end

  task automatic step(); @(negedge clk); endtask
  task automatic pulse_ei(); ei = 1; step(); ei = 0; step(); endtask
  task automatic set_mask(input logic [2:0] v); mwe = 1; mwd = v; step(); mwe = 0; step(); endtask

  task automatic take_irq(input string tag, input logic [15:0] ev, input logic [2:0] es,
                          input int elat, input int einta, input logic [7:0] eop);
    int lat = 1;
    int ni = 0;
    bnd = 1; step(); bnd = 0;
    while (!valid && lat < 20) begin
      if (inta) ni++;
      step(); lat++;
    end
    chk({tag, " R12 latency"}, 16'(lat), 16'(elat));
    chk({tag, " R7 inta cycles"}, 16'(ni), 16'(einta));
    chk({tag, " R1 vector"}, vec, ev);
    chk({tag, " R6 source"}, 16'(src), 16'(es));
    chk({tag, " R10 opcode"}, 16'(opc), 16'(eop));
    rdy = 1; step(); rdy = 0;
    chk({tag, " R11 released"}, 16'(valid), 16'd0);
  endtask

  task automatic no_irq(input string tag);
    int seen = 0;
    bnd = 1; step(); bnd = 0;
    for (int i = 0; i < 4; i++) begin
      if (valid || inta) seen++;
      step();
    end
    chk({tag, " nothing taken"}, 16'(seen), 16'd0);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1; step();
    chk("R2 valid", 16'(valid), 0);
    chk("R2 inta", 16'(inta), 0);
    chk("R2 ie", 16'(ie), 0);
    chk("R2 mask", 16'(msk), 16'h7);
    chk("R2 pend", 16'(pend), 0);

    trap = 1;
    take_irq("R5 trap masked/disabled", 16'h0024, 0, 1, 0, 8'h00);
    trap = 0;

    set_mask(3'b000);
    r65 = 1;
    no_irq("R4 disabled 6.5");
    pulse_ei();
    chk("R3 ei sets", 16'(ie), 1);
    set_mask(3'b010);
    no_irq("R4 masked 6.5");
    set_mask(3'b000);
    take_irq("R1 6.5", 16'h0034, 2, 1, 0, 8'h00);
    chk("R8 ie cleared", 16'(ie), 0);

    pulse_ei();
    r55 = 1;
    take_irq("R6 6.5 over 5.5", 16'h0034, 2, 1, 0, 8'h00);
    r65 = 0;
    pulse_ei();
    take_irq("R1 5.5", 16'h002C, 3, 1, 0, 8'h00);
    r55 = 0;

    r75 = 1; step(); r75 = 0; step();
    chk("R9 latched", 16'(pend), 1);
    pulse_ei();
    take_irq("R9 7.5", 16'h003C, 1, 1, 0, 8'h00);
    chk("R9 serviced clears", 16'(pend), 0);
    pulse_ei();
    no_irq("R9 no repeat");

    set_mask(3'b100);
    r75 = 1; step(); r75 = 0; step();
    no_irq("R4 masked 7.5");
    chk("R9 held while masked", 16'(pend), 1);
    clr75 = 1; step(); clr75 = 0; step();
    chk("R9 cleared", 16'(pend), 0);
    set_mask(3'b000);
    no_irq("R9 after clear");

    ei = 1; di = 1; step(); ei = 0; di = 0; step();
    chk("R3 di wins", 16'(ie), 0);

    intr = 1;
    no_irq("R7 intr disabled");
    pulse_ei();
    take_irq("R10 responder", 16'h0020, 4, NINTA + 1, NINTA, 8'hE7);
    pulse_ei();
    xdrv = 1; xdat = 8'hFF;
    take_irq("R10 external", 16'h0038, 4, NINTA + 1, NINTA, 8'hFF);
    xdrv = 0; intr = 0;

    pulse_ei();
    r55 = 1;
    bnd = 1; step(); bnd = 0;
    chk("R12 offer next", 16'(valid), 1);
    trap = 1; bnd = 1;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R11 held vector", vec, 16'h002C);
      chk("R11 held valid", 16'(valid), 1);
    end
    trap = 0; bnd = 0; r55 = 0;
    rdy = 1; step(); rdy = 0;
    chk("R11 released", 16'(valid), 0);

    pulse_ei();
    intr = 1; trap = 1;
    take_irq("R6 trap over intr", 16'h0024, 0, 1, 0, 8'h00);
    trap = 0; intr = 0;

    pulse_ei();
    trap = 1; ei = 1; bnd = 1; step(); ei = 0; bnd = 0; trap = 0;
    chk("R8 clear beats ei", 16'(ie), 0);
    rdy = 1; step(); rdy = 0; step();

    finish_run();
  end
endmodule